// File: doc/BRIEF.md
# Constant Off-Time Current Limiter

This block guards one power bridge against overcurrent. Each clock it looks at two digitized load-current codes, one for the high-side path and one for the low-side path, and a digitized junction-temperature code. When either current code reaches the present limit, it raises a chop request. That request forces the bridge into tri-state for a fixed number of microsecond ticks and then lets it conduct again. The limit is flat at normal temperatures. Inside a hot band it falls along a straight line, computed with integer interpolation over the temperature code. At the top of the band it clamps to a low floor, and the block asks for an overtemperature latch-off.

A separate hard-short detector compares the currents against two higher trip codes and requests a latch-off in the cycle after a trip. The bridge control pulses a strobe at every output transition. This strobe opens a blanking window during which hard-short detection is masked, so switching spikes do not cause a false trip. A minimum chop period keeps the chopping rate at or below 20 kHz.

The block's requests go to the bridge control logic, which owns the actual output state and the latches. Current codes use 0.1 A per LSB. The temperature code is degrees Celsius plus 40.

Top module: `chop_limiter`

## Requirements
- R1: While rstN is low, and in the first cycle after it, chopOff, shortReq and overTemp are all 0.
- R2: When hiCur or loCur is at or above the current limit code, and no chop period is in progress, chopOff is 1 after the next rising clock edge.
- R3: chopOff stays 1 for exactly OFF_US sampled usTick pulses (default 20). A tick in the same cycle as the start is not counted. chopOff is 0 after the edge that samples the last counted tick.
- R4: An over-limit current seen while chopOff is 1 neither extends nor restarts the off time.
- R5: A new chop cannot start until PERIOD_US ticks (default 50) have been counted since the previous start. The start then happens in the cycle after the edge that counts the last of those ticks, which caps the chopping rate at 20 kHz.
- R6: For temperature codes up to and including TEMP_KNEE (200, i.e. 160 °C), the current limit code is LIMIT_NOM (65, i.e. 6.5 A).
- R7: For codes between TEMP_KNEE and TEMP_TRIP (215, i.e. 175 °C), the limit is LIMIT_NOM - floor((LIMIT_NOM-LIMIT_FOLD)*(code-TEMP_KNEE)/(TEMP_TRIP-TEMP_KNEE)). For codes at or above TEMP_TRIP, the limit is LIMIT_FOLD (25, i.e. 2.5 A).
- R8: overTemp equals (tempCode >= TEMP_TRIP) as sampled at the previous rising edge.
- R9: Outside blanking, shortReq is 1 after an edge that samples hiCur > SHORT_HI (110) or loCur > SHORT_LO (80), and 0 otherwise.
- R10: edgeStrobe starts a blanking window that lasts for the strobe cycle plus BLANK_US counted ticks (default 16), and a new strobe reloads it. While the window is open, shortReq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse every microsecond |
| edgeStrobe | input | 1 | One-cycle pulse at each bridge output transition |
| hiCur | input | CUR_W (8) | High-side current code, 0.1 A per LSB |
| loCur | input | CUR_W (8) | Low-side current code, 0.1 A per LSB |
| tempCode | input | TEMP_W (8) | Junction temperature code, °C + 40 |
| chopOff | output | 1 | Tri-state request for the constant off time |
| shortReq | output | 1 | Hard-short latch-off request |
| overTemp | output | 1 | Overtemperature latch-off request |

## Verification
A wrong limit computation would show up at the chopOff port in the cycle right after a current code one below or exactly at the limit, at some temperature code. For that reason, every temperature code is swept with both boundary currents. A counter that loads or counts wrongly would show as chopOff falling one tick early or late, or as a second chop starting before the period has elapsed. Both appear within about fifty ticks of the start. A blanking counter that is off by one would let shortReq rise one tick too soon, or hold it back one tick too long, just after the window closes.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef struct packed {
    logic loadOff;
    logic loadBlank;
  } chopCtl_t;

  typedef struct packed {
    logic limitHit;
    logic shortHit;
    logic hot;
    logic offBusy;
    logic periodBusy;
    logic blankBusy;
  } chopStat_t;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int LOAD = 20,
  localparam int W = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic tick,
  output logic busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (load) cnt <= W'(LOAD);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/chop_datapath.sv
module chop_datapath import chop_pkg::*; #(
  parameter int CUR_W      = 8,
  parameter int TEMP_W     = 8,
  parameter int LIMIT_NOM  = 65,
  parameter int LIMIT_FOLD = 25,
  parameter int TEMP_KNEE  = 200,
  parameter int TEMP_TRIP  = 215,
  parameter int SHORT_HI   = 110,
  parameter int SHORT_LO   = 80,
  parameter int OFF_US     = 20,
  parameter int PERIOD_US  = 50,
  parameter int BLANK_US   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic [CUR_W-1:0]  hiCur,
  input  logic [CUR_W-1:0]  loCur,
  input  logic [TEMP_W-1:0] tempCode,
  input  chopCtl_t          ctl,
  output chopStat_t         stat
);
  localparam int SPAN = TEMP_TRIP - TEMP_KNEE;
  localparam int DROP = LIMIT_NOM - LIMIT_FOLD;
  localparam int PW   = CUR_W + TEMP_W + 1;

  logic [TEMP_W-1:0] deltaT;
  logic [PW-1:0]     product;
  logic [PW-1:0]     stepDown;
  logic [CUR_W-1:0]  limitCode;

  // Foldback: flat below the knee, linear inside the band, clamped above it.
  always_comb begin
    deltaT   = tempCode - TEMP_W'(TEMP_KNEE);
    product  = PW'(DROP) * PW'(deltaT);
    stepDown = product / PW'(SPAN);
    if (tempCode <= TEMP_W'(TEMP_KNEE))
      limitCode = CUR_W'(LIMIT_NOM);
    else if (tempCode >= TEMP_W'(TEMP_TRIP))
      limitCode = CUR_W'(LIMIT_FOLD);
    else
      limitCode = CUR_W'(LIMIT_NOM) - CUR_W'(stepDown);
  end

  assign stat.limitHit = (hiCur >= limitCode) || (loCur >= limitCode);
  assign stat.shortHit = (hiCur > CUR_W'(SHORT_HI)) || (loCur > CUR_W'(SHORT_LO));
  assign stat.hot      = (tempCode >= TEMP_W'(TEMP_TRIP));

  // Three tick-driven windows share one timer shape.
  localparam int NT = 3;
  localparam int LOADS [NT] = '{OFF_US, PERIOD_US, BLANK_US};
  logic [NT-1:0] loadVec;
  logic [NT-1:0] busyVec;
  assign loadVec = {ctl.loadBlank, ctl.loadOff, ctl.loadOff};

  for (genvar i = 0; i < NT; i++) begin : g_timer
    chop_timer #(.LOAD(LOADS[i])) u_tmr (
      .clk (clk),
      .rstN(rstN),
      .load(loadVec[i]),
      .tick(usTick),
      .busy(busyVec[i])
    );
  end

  assign stat.offBusy    = busyVec[0];
  assign stat.periodBusy = busyVec[1];
  assign stat.blankBusy  = busyVec[2];
endmodule

// File: rtl/chop_control.sv
module chop_control import chop_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      edgeStrobe,
  input  chopStat_t stat,
  output chopCtl_t  ctl,
  output logic      shortReq,
  output logic      overTemp
);
  // A chop may only start once both the off time and the period have run out.
  assign ctl.loadOff   = stat.limitHit && !stat.offBusy && !stat.periodBusy;
  assign ctl.loadBlank = edgeStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shortReq <= 1'b0;
      overTemp <= 1'b0;
    end else begin
      shortReq <= stat.shortHit && !stat.blankBusy && !edgeStrobe;
      overTemp <= stat.hot;
    end
  end
endmodule

// File: rtl/chop_limiter.sv
module chop_limiter import chop_pkg::*; #(
  parameter int CUR_W      = 8,
  parameter int TEMP_W     = 8,
  parameter int LIMIT_NOM  = 65,
  parameter int LIMIT_FOLD = 25,
  parameter int TEMP_KNEE  = 200,
  parameter int TEMP_TRIP  = 215,
  parameter int SHORT_HI   = 110,
  parameter int SHORT_LO   = 80,
  parameter int OFF_US     = 20,
  parameter int PERIOD_US  = 50,
  parameter int BLANK_US   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              edgeStrobe,
  input  logic [CUR_W-1:0]  hiCur,
  input  logic [CUR_W-1:0]  loCur,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              chopOff,
  output logic              shortReq,
  output logic              overTemp
);
  chopCtl_t  ctl;
  chopStat_t stat;

  chop_datapath #(
    .CUR_W(CUR_W), .TEMP_W(TEMP_W), .LIMIT_NOM(LIMIT_NOM), .LIMIT_FOLD(LIMIT_FOLD),
    .TEMP_KNEE(TEMP_KNEE), .TEMP_TRIP(TEMP_TRIP), .SHORT_HI(SHORT_HI),
    .SHORT_LO(SHORT_LO), .OFF_US(OFF_US), .PERIOD_US(PERIOD_US), .BLANK_US(BLANK_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .hiCur(hiCur), .loCur(loCur),
    .tempCode(tempCode), .ctl(ctl), .stat(stat)
  );

  chop_control u_ctl (
    .clk(clk), .rstN(rstN), .edgeStrobe(edgeStrobe), .stat(stat),
    .ctl(ctl), .shortReq(shortReq), .overTemp(overTemp)
  );

  assign chopOff = stat.offBusy;
endmodule

// File: rtl/chop_limiter_checker.sv
module chop_limiter_checker #(
  parameter int CUR_W     = 8,
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 215,
  parameter int SHORT_HI  = 110,
  parameter int SHORT_LO  = 80
) (
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic              edgeStrobe,
  input logic [CUR_W-1:0]  hiCur,
  input logic [CUR_W-1:0]  loCur,
  input logic [TEMP_W-1:0] tempCode,
  input logic              chopOff,
  input logic              shortReq,
  input logic              overTemp
);
  // R3: without a tick the off time cannot end
  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    chopOff && !usTick |=> chopOff);

  // R5: the cycle after the off time ends cannot start a new chop
  p_min_period_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chopOff) |=> !chopOff);

  // R10: a transition strobe masks the short request that follows it
  p_blank_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    edgeStrobe |=> !shortReq);

  // R9: a short request always has an over-trip current behind it
  p_short_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortReq) |-> $past(hiCur > CUR_W'(SHORT_HI) || loCur > CUR_W'(SHORT_LO)));

  // R8: a hot sample raises the overtemperature request
  p_hot_r8: assert property (@(posedge clk) disable iff (!rstN)
    tempCode >= TEMP_W'(TEMP_TRIP) |=> overTemp);

  // R8: a cool sample clears it
  p_cool_r8: assert property (@(posedge clk) disable iff (!rstN)
    tempCode < TEMP_W'(TEMP_TRIP) |=> !overTemp);
endmodule

bind chop_limiter chop_limiter_checker #(
  .CUR_W(CUR_W), .TEMP_W(TEMP_W), .TEMP_TRIP(TEMP_TRIP),
  .SHORT_HI(SHORT_HI), .SHORT_LO(SHORT_LO)
) u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick), .edgeStrobe(edgeStrobe),
  .hiCur(hiCur), .loCur(loCur), .tempCode(tempCode),
  .chopOff(chopOff), .shortReq(shortReq), .overTemp(overTemp)
);

// File: tb/chop_limiter_test.sv
module chop_limiter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic edgeStrobe = 1'b0;
  logic [7:0] hiCur = '0;
  logic [7:0] loCur = '0;
  logic [7:0] tempCode = '0;
  logic chopOff, shortReq, overTemp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chop_limiter uut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .edgeStrobe(edgeStrobe),
    .hiCur(hiCur), .loCur(loCur), .tempCode(tempCode),
    .chopOff(chopOff), .shortReq(shortReq), .overTemp(overTemp)
  );

  function automatic int limitOf(int t);
    if (t <= 200) return 65;
    if (t >= 215) return 25;
    return 65 - (40 * (t - 200)) / 15;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    usTick = 1'b1;
    repeat (n) step();
    usTick = 1'b0;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Let any chop period run out with quiet currents.
  task automatic drain();
    hiCur = '0;
    loCur = '0;
    step();
    ticks(50);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tempCode = 8'd100;
    repeat (3) step();
    check("R1 chopOff in reset", chopOff, 0);
    check("R1 shortReq in reset", shortReq, 0);
    check("R1 overTemp in reset", overTemp, 0);
    rstN = 1'b1;
    step();
    check("R1 chopOff after reset", chopOff, 0);
    check("R1 shortReq after reset", shortReq, 0);

    // R2/R3: start with a tick in the same cycle; that tick does not count
    hiCur = 8'd70;
    usTick = 1'b1;
    step();
    usTick = 1'b0;
    check("R2 chop start", chopOff, 1);
    ticks(19);
    check("R3 still off after OFF_US-1 ticks", chopOff, 1);
    // R4: an over-limit current during the off time does not extend it
    loCur = 8'd90;
    hiCur = 8'd120;
    step();
    check("R4 retrigger ignored", chopOff, 1);
    hiCur = 8'd70;
    loCur = 8'd0;
    ticks(1);
    check("R3 off ends after OFF_US ticks", chopOff, 0);
    // R5: current still high, period not yet over
    ticks(29);
    check("R5 no start before period", chopOff, 0);
    ticks(1);
    check("R5 no start on last period tick", chopOff, 0);
    step();
    check("R5 start after period", chopOff, 1);
    drain();

    // R9: loCur sweep with no blanking
    for (int c = 0; c < 256; c++) begin
      loCur = 8'(c);
      step();
      check("R9 loCur short trip", shortReq, (c > 80) ? 1 : 0);
    end
    loCur = '0;
    hiCur = 8'd110;
    step();
    check("R9 hiCur at trip code", shortReq, 0);
    hiCur = 8'd111;
    step();
    check("R9 hiCur above trip code", shortReq, 1);
    hiCur = '0;
    drain();

    // R10: blanking window masks a hard short
    hiCur = 8'd120;
    edgeStrobe = 1'b1;
    step();
    edgeStrobe = 1'b0;
    check("R10 masked on strobe", shortReq, 0);
    ticks(15);
    check("R10 masked after 15 ticks", shortReq, 0);
    ticks(1);
    check("R10 masked on last blank tick", shortReq, 0);
    step();
    check("R10 short after blanking", shortReq, 1);
    // R10: a second strobe reloads the window
    edgeStrobe = 1'b1;
    step();
    edgeStrobe = 1'b0;
    ticks(10);
    edgeStrobe = 1'b1;
    step();
    edgeStrobe = 1'b0;
    ticks(10);
    check("R10 retriggered blank", shortReq, 0);
    ticks(6);
    step();
    check("R10 short after retriggered blank", shortReq, 1);
    drain();

    // R6/R7/R8: full temperature sweep with the boundary currents
    for (int t = 0; t < 256; t++) begin
      int lim;
      lim = limitOf(t);
      tempCode = 8'(t);
      if (t % 2 == 0) hiCur = 8'(lim - 1); else loCur = 8'(lim - 1);
      step();
      check((t <= 200) ? "R6 below limit" : "R7 below limit", chopOff, 0);
      check("R8 overtemp", overTemp, (t >= 215) ? 1 : 0);
      if (t % 2 == 0) hiCur = 8'(lim); else loCur = 8'(lim);
      step();
      check((t <= 200) ? "R6 at limit" : "R7 at limit", chopOff, 1);
      drain();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule